// File: doc/BRIEF.md
# GPIO Event Detect and Interrupt Unit

This block watches every pin of a 54-pin general-purpose I/O bank and records the conditions that software has chosen to watch for. Each pin has six detect sources, and each source has its own enable: a rising edge and a falling edge seen on the system clock, a high level, a low level, and a rising edge and a falling edge captured straight from the raw pin. The raw-pin capture catches pulses that are shorter than one clock period. When an enabled source fires, the pin's sticky status bit is set. Software clears the bit by writing a one to it.

The pins are split into 32-bit banks. Bank 0 holds pins 0 to 31 and bank 1 holds pins 32 to 53. Each bank drives one interrupt line, which is high while any status bit of that bank is set. The registers sit in the I/O block's shared address map. The word for bank b of a register lives at that register's base plus 4·b, and pin p occupies bit p mod 32 of the word for bank p/32. The synchronized pin levels come from the core's existing synchronizer. The interrupt lines feed an external interrupt controller.

Top module: `gpev_unit`

## Requirements
- R1: After reset every enable bit and every status bit reads 0, and both interrupt lines are low.
- R2: When the rising enable (base 0x4C) is set for a pin, a 0-to-1 change on its synchronized input sets the pin's status bit at the next clock edge. The enable register reads back the value written to it.
- R3: When the falling enable (base 0x58) is set for a pin, a 1-to-0 change on its synchronized input sets its status bit at the next clock edge. A rising change on that pin does not set the bit.
- R4: When a pin has both the rising and the falling enable set, both edge directions set its status bit.
- R5: When the high-level enable (base 0x64) is set, the status bit is set on every edge while the synchronized input is 1. A clear written while the level holds leaves the bit at 1.
- R6: When the low-level enable (base 0x70) is set, the status bit is set on every edge while the synchronized input is 0.
- R7: When the raw rising enable (base 0x7C) is set, a rising edge on the raw pin sets the status bit on the third clock edge after the raw edge. This holds even for a pulse that starts and ends between two clock edges.
- R8: When the raw falling enable (base 0x88) is set, a falling edge on the raw pin sets the status bit on the third clock edge after the raw edge.
- R9: The status register (base 0x40) clears each bit written with 1 and leaves each bit written with 0 unchanged. Read data for pins that do not exist is 0.
- R10: If a clear of a bit and a new event for that bit fall in the same cycle, the bit ends up set.
- R11: A status bit stays set after its source is disabled until a one is written to it. A disabled source sets nothing.
- R12: irq[0] is high exactly while any status bit of pins 0 to 31 is set. irq[1] is high exactly while any status bit of pins 32 to 53 is set.
- R13: A pin with no enabled source never sets its status bit, whatever its inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, clears all enables, status and edge history |
| pin_sync | input | 54 | Pin levels already synchronized to clk |
| pin_raw | input | 54 | Raw pin levels for the asynchronous edge capture |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 8 | Register write byte address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 8 | Register read byte address |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| irq | output | 2 | One interrupt line per bank |

## Verification
Each result is due a fixed number of clock edges after its stimulus, so every check is placed at a precise edge. A synchronous edge, a level, or a register write takes effect at the first clock edge after it is driven. A raw-pin edge takes effect at the third edge, because it passes through a two-stage synchronizer and an edge compare. The interrupt lines and the read data follow the status register with no added delay. All inputs are driven on falling clock edges. The scoreboard samples one nanosecond later, so it sees the state left by the preceding rising edge. For latency, the checks read the status both one edge early, where it must still be clear, and on the due edge.

// File: rtl/gpev_pkg.sv
package gpev_pkg;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 32;
  localparam int NUM_SRC = 6;

  // source indices; also the bit order of the per-pin condition vector
  localparam int SRC_RISE  = 0;
  localparam int SRC_FALL  = 1;
  localparam int SRC_HIGH  = 2;
  localparam int SRC_LOW   = 3;
  localparam int SRC_ARISE = 4;
  localparam int SRC_AFALL = 5;
  localparam int IDX_STAT  = NUM_SRC;

  localparam logic [ADDR_W-1:0] STATUS_BASE = 8'h40;
  localparam int BANK_STRIDE = 4;

  function automatic logic [ADDR_W-1:0] reg_base(input int idx);
    case (idx)
      SRC_RISE:  return 8'h4C;
      SRC_FALL:  return 8'h58;
      SRC_HIGH:  return 8'h64;
      SRC_LOW:   return 8'h70;
      SRC_ARISE: return 8'h7C;
      SRC_AFALL: return 8'h88;
      default:   return STATUS_BASE;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] reg_addr(input int idx, input int bank);
    return reg_base(idx) + ADDR_W'(bank * BANK_STRIDE);
  endfunction

  function automatic int num_banks(input int pins);
    return (pins + DATA_W - 1) / DATA_W;
  endfunction

  function automatic logic any_hit(input logic [NUM_SRC-1:0] en,
                                   input logic [NUM_SRC-1:0] cond);
    return |(en & cond);
  endfunction
endpackage

// File: rtl/gpev_sync_edge.sv
module gpev_sync_edge #(
  parameter int NUM_PINS = 54
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_sync,
  output logic [NUM_PINS-1:0] rise_ev,
  output logic [NUM_PINS-1:0] fall_ev,
  output logic [NUM_PINS-1:0] level
);
  logic [NUM_PINS-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= pin_sync;
  end

  assign rise_ev = pin_sync & ~prev_q;
  assign fall_ev = ~pin_sync & prev_q;
  assign level   = pin_sync;
endmodule

// File: rtl/gpev_async_edge.sv
module gpev_async_edge #(
  parameter int NUM_PINS = 54
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_raw,
  output logic [NUM_PINS-1:0] arise_ev,
  output logic [NUM_PINS-1:0] afall_ev
);
  logic [NUM_PINS-1:0] tog_r, tog_f;

  // each raw edge flips a toggle flop clocked by the pin itself
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_cap
    logic tr_q, tf_q;
    always_ff @(posedge pin_raw[p] or negedge rst_n) begin
      if (!rst_n) tr_q <= 1'b0;
      else        tr_q <= ~tr_q;
    end
    always_ff @(negedge pin_raw[p] or negedge rst_n) begin
      if (!rst_n) tf_q <= 1'b0;
      else        tf_q <= ~tf_q;
    end
    assign tog_r[p] = tr_q;
    assign tog_f[p] = tf_q;
  end

  logic [NUM_PINS-1:0] r_s1, r_s2, r_s3, f_s1, f_s2, f_s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_s1 <= '0; r_s2 <= '0; r_s3 <= '0;
      f_s1 <= '0; f_s2 <= '0; f_s3 <= '0;
    end else begin
      r_s1 <= tog_r; r_s2 <= r_s1; r_s3 <= r_s2;
      f_s1 <= tog_f; f_s2 <= f_s1; f_s3 <= f_s2;
    end
  end

  assign arise_ev = r_s2 ^ r_s3;
  assign afall_ev = f_s2 ^ f_s3;
endmodule

// File: rtl/gpev_regs.sv
module gpev_regs
  import gpev_pkg::*;
#(
  parameter int NUM_PINS  = 54,
  parameter int NUM_BANKS = 2
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                wr_en,
  input  logic [ADDR_W-1:0]                   wr_addr,
  input  logic [DATA_W-1:0]                   wr_data,
  input  logic [ADDR_W-1:0]                   rd_addr,
  output logic [DATA_W-1:0]                   rd_data,
  input  logic [NUM_PINS-1:0]                 ev,
  output logic [NUM_SRC-1:0][NUM_PINS-1:0]    en_q,
  output logic [NUM_PINS-1:0]                 status_q,
  output logic [NUM_PINS-1:0]                 clr
);
  always_comb begin
    for (int p = 0; p < NUM_PINS; p++)
      clr[p] = wr_en && (wr_addr == reg_addr(IDX_STAT, p / DATA_W))
               && wr_data[p % DATA_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (wr_en) begin
      for (int s = 0; s < NUM_SRC; s++)
        for (int p = 0; p < NUM_PINS; p++)
          if (wr_addr == reg_addr(s, p / DATA_W))
            en_q[s][p] <= wr_data[p % DATA_W];
    end
  end

  // new event takes priority over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= (status_q & ~clr) | ev;
  end

  logic [NUM_SRC:0][NUM_BANKS-1:0][DATA_W-1:0] words;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    for (genvar j = 0; j < DATA_W; j++) begin : g_bit
      localparam int PIN = b * DATA_W + j;
      if (PIN < NUM_PINS) begin : g_live
        for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
          assign words[s][b][j] = en_q[s][PIN];
        end
        assign words[IDX_STAT][b][j] = status_q[PIN];
      end else begin : g_pad
        for (genvar s = 0; s <= NUM_SRC; s++) begin : g_zero
          assign words[s][b][j] = 1'b0;
        end
      end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int s = 0; s <= NUM_SRC; s++)
      for (int b = 0; b < NUM_BANKS; b++)
        if (rd_addr == reg_addr(s, b)) rd_data = words[s][b];
  end
endmodule

// File: rtl/gpev_unit.sv
module gpev_unit
  import gpev_pkg::*;
#(
  parameter int NUM_PINS  = 54,
  parameter int NUM_BANKS = num_banks(NUM_PINS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PINS-1:0]  pin_sync,
  input  logic [NUM_PINS-1:0]  pin_raw,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [DATA_W-1:0]    rd_data,
  output logic [NUM_BANKS-1:0] irq
);
  logic [NUM_PINS-1:0] rise_ev, fall_ev, level, arise_ev, afall_ev;
  logic [NUM_PINS-1:0] ev_vec, clr_vec, status_vec;
  logic [NUM_SRC-1:0][NUM_PINS-1:0] en_q;

  gpev_sync_edge #(.NUM_PINS(NUM_PINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_sync(pin_sync),
    .rise_ev(rise_ev), .fall_ev(fall_ev), .level(level)
  );

  gpev_async_edge #(.NUM_PINS(NUM_PINS)) u_async (
    .clk(clk), .rst_n(rst_n), .pin_raw(pin_raw),
    .arise_ev(arise_ev), .afall_ev(afall_ev)
  );

  gpev_regs #(.NUM_PINS(NUM_PINS), .NUM_BANKS(NUM_BANKS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .ev(ev_vec), .en_q(en_q), .status_q(status_vec), .clr(clr_vec)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic [NUM_SRC-1:0] cond, en_p;
    assign cond = {afall_ev[p], arise_ev[p], ~level[p], level[p],
                   fall_ev[p], rise_ev[p]};
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_en
      assign en_p[s] = en_q[s][p];
    end
    assign ev_vec[p] = any_hit(en_p, cond);
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_irq
    localparam int LO = b * DATA_W;
    localparam int HI = ((LO + DATA_W) < NUM_PINS ? (LO + DATA_W) : NUM_PINS) - 1;
    assign irq[b] = |status_vec[HI:LO];
  end
endmodule

// File: rtl/gpev_unit_chk.sv
module gpev_unit_chk #(
  parameter int NUM_PINS  = 54,
  parameter int NUM_BANKS = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_PINS-1:0]  ev,
  input logic [NUM_PINS-1:0]  clr,
  input logic [NUM_PINS-1:0]  status,
  input logic [NUM_BANKS-1:0] irq
);
  function automatic logic [NUM_PINS-1:0] bank_mask(input int b);
    logic [NUM_PINS-1:0] m;
    for (int p = 0; p < NUM_PINS; p++) m[p] = ((p / 32) == b);
    return m;
  endfunction

  // R10: an event always lands, even against a clear
  p_event_sets_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ev != '0) |=> ((status & $past(ev)) == $past(ev)));

  // R11: an uncleared bit stays set
  p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & $past(status & ~clr)) == $past(status & ~clr)));

  // R13: no bit rises without an event
  p_no_spurious_r13: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & ~$past(status) & ~$past(ev)) == '0));

  // R9: a clear without a competing event empties the bit
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & $past(clr & ~ev)) == '0));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_irq_chk
    // R12: a bank line rises only after an event in that bank
    p_irq_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq[b]) |-> ($past(ev & bank_mask(b)) != '0));
  end
endmodule

bind gpev_unit gpev_unit_chk #(.NUM_PINS(NUM_PINS), .NUM_BANKS(NUM_BANKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev(ev_vec), .clr(clr_vec),
  .status(status_vec), .irq(irq)
);

// File: tb/gpev_unit_tb.sv
`timescale 1ns/1ps
module gpev_unit_tb;
  localparam int NP = 54;
  localparam int NB = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pin_sync = '0;
  logic [NP-1:0] pin_raw = '0;
  logic          wr_en = 1'b0;
  logic [7:0]    wr_addr = '0;
  logic [31:0]   wr_data = '0;
  logic [7:0]    rd_addr = '0;
  logic [31:0]   rd_data;
  logic [NB-1:0] irq;

  gpev_unit u_dut (
    .clk(clk), .rst_n(rst_n), .pin_sync(pin_sync), .pin_raw(pin_raw),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  always #10 clk = ~clk;

  typedef struct {
    logic [7:0]  addr;
    bit          is_irq;
    int          bank;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t exp_q[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // monitor: pops each expected item and compares at the sample point
  initial begin
    forever begin
      item_t it;
      logic [31:0] act;
      wait (exp_q.size() != 0);
      #1;
      it = exp_q.pop_front();
      act = it.is_irq ? {31'b0, irq[it.bank]} : rd_data;
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s addr=%h actual=%h expected=%h", it.tag, it.addr, act, it.exp);
      end
    end
  end

  task automatic tick(input int n = 1);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic exp_reg(input logic [7:0] a, input logic [31:0] e, input string tag);
    item_t it;
    rd_addr = a;
    it.addr = a; it.is_irq = 1'b0; it.bank = 0; it.exp = e; it.tag = tag;
    exp_q.push_back(it);
    wait (exp_q.size() == 0);
  endtask

  task automatic exp_irq(input int b, input logic e, input string tag);
    item_t it;
    it.addr = 8'hFF; it.is_irq = 1'b1; it.bank = b; it.exp = {31'b0, e}; it.tag = tag;
    exp_q.push_back(it);
    wait (exp_q.size() == 0);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    exp_reg(8'h40, 32'h0, "R1 status bank0");
    exp_reg(8'h44, 32'h0, "R1 status bank1");
    exp_reg(8'h4C, 32'h0, "R1 rise enable");
    exp_reg(8'h8C, 32'h0, "R1 async fall enable bank1");
    exp_irq(0, 1'b0, "R1 irq0");
    exp_irq(1, 1'b0, "R1 irq1");

    // enables: rise pins 3,7,12; fall pins 10,12
    wr(8'h4C, 32'h0000_1088);
    wr(8'h58, 32'h0000_1400);
    exp_reg(8'h4C, 32'h0000_1088, "R2 enable readback");

    // R13 / R3: unenabled pin 4 and rising on fall-only pin 10
    pin_sync[4] = 1'b1; pin_sync[10] = 1'b1;
    tick();
    exp_reg(8'h40, 32'h0, "R13 no enabled source / R3 wrong edge");
    exp_irq(0, 1'b0, "R13 irq0 quiet");

    // R2: rising edge on pin 3, due one edge later
    pin_sync[3] = 1'b1;
    exp_reg(8'h40, 32'h0, "R2 not before edge");
    tick();
    exp_reg(8'h40, 32'h0000_0008, "R2 rising sets");
    exp_irq(0, 1'b1, "R12 irq0 high");

    // R3: falling edge on pin 10
    pin_sync[10] = 1'b0;
    tick();
    exp_reg(8'h40, 32'h0000_0408, "R3 falling sets");

    // R4: both edges on pin 12
    pin_sync[12] = 1'b1;
    tick();
    exp_reg(8'h40, 32'h0000_1408, "R4 rise of both-edge pin");
    wr(8'h40, 32'h0000_1000);
    exp_reg(8'h40, 32'h0000_0408, "R4 cleared");
    pin_sync[12] = 1'b0;
    tick();
    exp_reg(8'h40, 32'h0000_1408, "R4 fall of both-edge pin");

    // R9: zero write leaves bits, one write clears
    wr(8'h40, 32'h0);
    exp_reg(8'h40, 32'h0000_1408, "R9 zero write no effect");
    wr(8'h40, 32'h0000_1408);
    exp_reg(8'h40, 32'h0, "R9 clear by one");
    exp_irq(0, 1'b0, "R12 irq0 low after clear");

    // R10: clear and new event on pin 7 in one cycle
    pin_sync[7] = 1'b1;
    tick();
    pin_sync[7] = 1'b0;
    tick();
    exp_reg(8'h40, 32'h0000_0080, "R10 prior event");
    wr_en = 1'b1; wr_addr = 8'h40; wr_data = 32'h0000_0080;
    pin_sync[7] = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    exp_reg(8'h40, 32'h0000_0080, "R10 event beats clear");
    wr(8'h40, 32'h0000_0080);
    exp_reg(8'h40, 32'h0, "R10 later clear");

    // R11: disable keeps latched bit, disabled source sets nothing
    pin_sync[3] = 1'b0;
    tick();
    pin_sync[3] = 1'b1;
    tick();
    wr(8'h4C, 32'h0000_1080);
    exp_reg(8'h40, 32'h0000_0008, "R11 kept after disable");
    wr(8'h40, 32'h0000_0008);
    pin_sync[3] = 1'b0;
    tick();
    pin_sync[3] = 1'b1;
    tick();
    exp_reg(8'h40, 32'h0, "R11 disabled source silent");

    // R5: high level on pin 40 (bank1 bit 8)
    wr(8'h68, 32'h0000_0100);
    pin_sync[40] = 1'b1;
    tick();
    exp_reg(8'h44, 32'h0000_0100, "R5 high level sets");
    exp_irq(1, 1'b1, "R12 irq1 high");
    exp_irq(0, 1'b0, "R12 irq0 independent");
    wr(8'h44, 32'h0000_0100);
    exp_reg(8'h44, 32'h0000_0100, "R5 level persists over clear");
    pin_sync[40] = 1'b0;
    tick();
    wr(8'h44, 32'h0000_0100);
    exp_reg(8'h44, 32'h0, "R5 clear after level drops");
    exp_irq(1, 1'b0, "R12 irq1 low");

    // R6: low level on pin 20
    wr(8'h70, 32'h0010_0000);
    tick();
    exp_reg(8'h40, 32'h0010_0000, "R6 low level sets");
    pin_sync[20] = 1'b1;
    wr(8'h70, 32'h0);
    wr(8'h40, 32'h0010_0000);
    exp_reg(8'h40, 32'h0, "R6 cleared");

    // R7: short raw pulse on pin 5, due on third edge
    wr(8'h7C, 32'h0000_0020);
    #2 pin_raw[5] = 1'b1;
    #3 pin_raw[5] = 1'b0;
    @(negedge clk);
    tick();
    exp_reg(8'h40, 32'h0, "R7 not before third edge");
    tick();
    exp_reg(8'h40, 32'h0000_0020, "R7 short pulse caught");
    wr(8'h40, 32'h0000_0020);
    exp_reg(8'h40, 32'h0, "R7 cleared");

    // R8: raw falling on pin 50 (bank1 bit 18)
    wr(8'h8C, 32'h0004_0000);
    #2 pin_raw[50] = 1'b1;
    #3 pin_raw[50] = 1'b0;
    @(negedge clk);
    tick();
    exp_reg(8'h44, 32'h0, "R8 not before third edge");
    tick();
    exp_reg(8'h44, 32'h0004_0000, "R8 raw falling sets");
    exp_irq(1, 1'b1, "R8 irq1 raised");
    wr(8'h44, 32'hFFFF_FFFF);
    exp_reg(8'h44, 32'h0, "R9 full clear bank1");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule